// File: doc/BRIEF.md
# OTP Programming Precondition Sequencer

This block decides whether a configuration image may be burned into one-time-programmable storage, and burns it when allowed. A host raises one of two requests: a check-only request that reports whether programming could go ahead, or a program request that performs the write when every condition holds. The block looks at the access-mode flags, the lock input, the measured stack voltage against a minimum and a maximum, the measured temperature against a ceiling, the number of signature slots already used, and whether each changed byte still has room in the two XOR images.

The storage holds two images per byte. The value a byte reads back as is the first image XOR the second image XOR a fixed default. A byte whose target already equals that merged value is left alone. A changed byte is written into the first image that is still all-zero, with the value that turns the merged result into the target. Before anything is written, a scan pass visits every byte, so a capacity failure is found, and its lowest address latched, before any byte is touched. Each byte actually written costs a fixed, parameterised number of cycles. This models the slow cell programming time.

The result is a status byte with fixed bit positions plus a 16-bit failing address, presented when a one-cycle done pulse is raised.

Top module: `otp_prog_seq`

## Requirements
- R1: Bit 7 of `status` is 1 exactly when bits 5, 4, 3, 2, 1 and 0 are all 0. Bit 6 always reads 0.
- R2: Bit 5 of `status` is 1 when `mode_full` and `mode_cfg` are not both 1, or when `lock` is 1.
- R3: Bit 2 of `status` is 1 when `temp > t_max`. Bit 1 is 1 when `stack_v < v_min`. Bit 0 is 1 when `stack_v > v_max`. All three comparisons are unsigned and strict.
- R4: Bit 4 of `status` is 1 when SIG_SLOTS successful programs have already completed since reset.
- R5: Bit 3 of `status` is 1 when some byte differs from its target and both of its images are already nonzero. `fail_addr` then holds the lowest such byte index, with bits 7:0 as the low byte and bits 15:8 as the high byte. Otherwise `fail_addr` is 0.
- R6: A check request never changes the stored images. `busy` stays high for exactly N_BYTES+1 cycles.
- R7: A program request with all fault bits clear writes every byte that differs from its target. The write goes into the first image that is all-zero. Afterwards `rd_data` equals the target at every address, and `status` is 0x80.
- R8: A successful program keeps `busy` high for exactly 2*N_BYTES+1+k*PROG_CYCLES cycles, where k is the number of bytes that differed. Unchanged bytes add no programming delay.
- R9: A program request with any fault bit set writes nothing. It reports the same status, `fail_addr` and busy length as a check request would.
- R10: A request seen while `busy` is high is ignored. If both requests arrive together, the check request is the one served.
- R11: After reset, `busy`, `done`, `status` and `fail_addr` are 0. Every byte reads its default, which is (i*29 XOR 0xA5) truncated to 8 bits for byte i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_check | input | 1 | Check-only request, one cycle |
| req_prog | input | 1 | Program request, one cycle |
| mode_full | input | 1 | Full-access mode active |
| mode_cfg | input | 1 | Configuration-update mode active |
| lock | input | 1 | Storage locked against modification |
| stack_v | input | VW | Measured stack voltage |
| temp | input | VW | Measured internal temperature |
| v_min | input | VW | Lowest stack voltage allowed for programming |
| v_max | input | VW | Highest stack voltage allowed for programming |
| t_max | input | VW | Highest temperature allowed for programming |
| cfg_target | input | N_BYTES*8 | Target configuration, byte i at bits 8i+7:8i |
| rd_addr | input | AW | Read-back byte address |
| rd_data | output | 8 | Merged value of byte rd_addr |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse when status is valid |
| status | output | 8 | Bit-mapped result byte |
| fail_addr | output | 16 | First byte without image capacity |

## Verification
The assertions check on every cycle that a write goes only into an empty image slot, and only during a program request with no latched fault. They also check that each write is followed by a cycle without one, that a request arriving while busy leaves the current operation unchanged, that the signature count stays within bound, and that `fail_addr` agrees with the capacity bit. Only the bench scenarios can show the full status mapping across the mode, lock, voltage and temperature sweep. The same holds for the exact busy lengths that prove programming time scales with the changed-byte count, for the selection of the lowest failing address, and for the read-back contents after successful and refused programs.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_PROG,
        S_WAIT,
        S_FIN
    } seq_state_e;

    // status byte bit positions
    localparam int unsigned ST_OK     = 7;
    localparam int unsigned ST_RSVD   = 6;
    localparam int unsigned ST_LOCK   = 5;
    localparam int unsigned ST_NOSIG  = 4;
    localparam int unsigned ST_NODATA = 3;
    localparam int unsigned ST_HOT    = 2;
    localparam int unsigned ST_LOWV   = 1;
    localparam int unsigned ST_HIGHV  = 0;

    // factory default of byte i
    function automatic logic [7:0] otp_default(input int unsigned i);
        return 8'((i * 29) ^ 165);
    endfunction

endpackage

// File: rtl/otp_cond_eval.sv
module otp_cond_eval #(
    parameter int unsigned VW = 16
) (
    input  logic          mode_full,
    input  logic          mode_cfg,
    input  logic          lock,
    input  logic [VW-1:0] stack_v,
    input  logic [VW-1:0] temp,
    input  logic [VW-1:0] v_min,
    input  logic [VW-1:0] v_max,
    input  logic [VW-1:0] t_max,
    output logic [3:0]    env_flt   // {locked, hot, low, high}
);

    always_comb begin
        env_flt[3] = !(mode_full && mode_cfg) || lock;
        env_flt[2] = temp > t_max;
        env_flt[1] = stack_v < v_min;
        env_flt[0] = stack_v > v_max;
    end

endmodule

// File: rtl/otp_image_store.sv
module otp_image_store
    import otp_seq_pkg::*;
#(
    parameter int unsigned N_BYTES = 32,
    localparam int unsigned AW = $clog2(N_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          wsel,      // 0: first image, 1: second image
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] ctl_addr,
    output logic [7:0]    ctl_a,
    output logic [7:0]    ctl_b,
    output logic [7:0]    ctl_merged,
    input  logic [AW-1:0] host_addr,
    output logic [7:0]    host_merged
);

    typedef struct packed {
        logic [N_BYTES-1:0][7:0] a;
        logic [N_BYTES-1:0][7:0] b;
    } img_t;

    img_t img_d, img_q;
    logic [N_BYTES-1:0][7:0] merged;

    for (genvar gi = 0; gi < N_BYTES; gi++) begin : g_merge
        assign merged[gi] = img_q.a[gi] ^ img_q.b[gi] ^ otp_default(gi);
    end

    always_comb begin
        img_d = img_q;
        if (we) begin
            if (wsel) begin
                img_d.b[waddr] = img_q.b[waddr] | wdata;
            end else begin
                img_d.a[waddr] = img_q.a[waddr] | wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            img_q <= '0;
        end else begin
            img_q <= img_d;
        end
    end

    assign ctl_a       = img_q.a[ctl_addr];
    assign ctl_b       = img_q.b[ctl_addr];
    assign ctl_merged  = merged[ctl_addr];
    assign host_merged = merged[host_addr];

    // R7
    slot_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (wsel ? (img_q.a[waddr] != 8'h00 && img_q.b[waddr] == 8'h00)
                     : (img_q.a[waddr] == 8'h00)));

endmodule

// File: rtl/otp_seq_ctrl.sv
module otp_seq_ctrl
    import otp_seq_pkg::*;
#(
    parameter int unsigned N_BYTES     = 32,
    parameter int unsigned PROG_CYCLES = 25000,
    parameter int unsigned SIG_SLOTS   = 8,
    localparam int unsigned AW = $clog2(N_BYTES),
    localparam int unsigned CW = $clog2(PROG_CYCLES + 1),
    localparam int unsigned SW = $clog2(SIG_SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_check,
    input  logic          req_prog,
    input  logic [3:0]    env_flt,
    input  logic [7:0]    cur_a,
    input  logic [7:0]    cur_b,
    input  logic [7:0]    cur_merged,
    input  logic [7:0]    cur_target,
    output logic [AW-1:0] idx,
    output logic          we,
    output logic          wsel,
    output logic [7:0]    wdata,
    output logic          busy,
    output logic          done,
    output logic [7:0]    status,
    output logic [15:0]   fail_addr
);

    localparam logic [AW-1:0] LAST = AW'(N_BYTES - 1);
    localparam logic [CW-1:0] WAIT_LOAD = CW'(PROG_CYCLES - 1);
    localparam logic [SW-1:0] SIG_MAX = SW'(SIG_SLOTS);

    typedef struct packed {
        seq_state_e    st;
        logic          op_prog;
        logic [AW-1:0] idx;
        logic [CW-1:0] cnt;
        logic [5:0]    flt;      // bit3 unused here, capacity kept apart
        logic          nodata;
        logic [15:0]   fail;
        logic [7:0]    status;
        logic [15:0]   fail_o;
        logic          done;
        logic [SW-1:0] sig;
    } ctl_t;

    ctl_t d, q;
    logic chg, slot_full;
    logic [5:0] fin_flt;

    assign chg       = cur_target != cur_merged;
    assign slot_full = (cur_a != 8'h00) && (cur_b != 8'h00);
    assign fin_flt   = {q.flt[5:4], q.nodata, q.flt[2:0]};

    always_comb begin
        d     = q;
        d.done = 1'b0;
        we    = 1'b0;
        wsel  = cur_a != 8'h00;
        wdata = cur_target ^ cur_merged;
        case (q.st)
            S_IDLE: begin
                if (req_check || req_prog) begin
                    d.st      = S_SCAN;
                    d.op_prog = !req_check;
                    d.idx     = '0;
                    d.nodata  = 1'b0;
                    d.fail    = '0;
                    d.flt     = {env_flt[3], q.sig == SIG_MAX, 1'b0, env_flt[2:0]};
                end
            end
            S_SCAN: begin
                if (chg && slot_full && !q.nodata) begin
                    d.nodata = 1'b1;
                    d.fail   = 16'(q.idx);
                end
                if (q.idx == LAST) begin
                    if (q.op_prog && q.flt == 6'd0 && !d.nodata) begin
                        d.st  = S_PROG;
                        d.idx = '0;
                    end else begin
                        d.st = S_FIN;
                    end
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            S_PROG: begin
                if (chg) begin
                    we    = 1'b1;
                    d.st  = S_WAIT;
                    d.cnt = WAIT_LOAD;
                end else if (q.idx == LAST) begin
                    d.st = S_FIN;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            S_WAIT: begin
                if (q.cnt == '0) begin
                    if (q.idx == LAST) begin
                        d.st = S_FIN;
                    end else begin
                        d.st  = S_PROG;
                        d.idx = q.idx + 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            S_FIN: begin
                d.status = {~|fin_flt, 1'b0, fin_flt};
                d.fail_o = q.fail;
                d.done   = 1'b1;
                if (q.op_prog && ~|fin_flt) begin
                    d.sig = q.sig + 1'b1;
                end
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign idx       = q.idx;
    assign busy      = q.st != S_IDLE;
    assign done      = q.done;
    assign status    = q.status;
    assign fail_addr = q.fail_o;

    // R9
    no_write_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (q.flt == 6'd0 && !q.nodata));

    // R6
    check_never_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> q.op_prog);

    // R8
    write_then_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we);

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (req_check || req_prog)) |=> $stable(q.op_prog));

    // R4
    sig_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sig <= SIG_MAX);

    // R5
    fail_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status[ST_NODATA] ? (fail_addr < 16'(N_BYTES)) : (fail_addr == 16'd0)));

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int unsigned N_BYTES     = 32,
    parameter int unsigned PROG_CYCLES = 25000,
    parameter int unsigned SIG_SLOTS   = 8,
    parameter int unsigned VW          = 16,
    localparam int unsigned AW = $clog2(N_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_check,
    input  logic                 req_prog,
    input  logic                 mode_full,
    input  logic                 mode_cfg,
    input  logic                 lock,
    input  logic [VW-1:0]        stack_v,
    input  logic [VW-1:0]        temp,
    input  logic [VW-1:0]        v_min,
    input  logic [VW-1:0]        v_max,
    input  logic [VW-1:0]        t_max,
    input  logic [N_BYTES*8-1:0] cfg_target,
    input  logic [AW-1:0]        rd_addr,
    output logic [7:0]           rd_data,
    output logic                 busy,
    output logic                 done,
    output logic [7:0]           status,
    output logic [15:0]          fail_addr
);

    logic [3:0]    env_flt;
    logic [AW-1:0] ctl_idx;
    logic          we, wsel;
    logic [7:0]    wdata, cur_a, cur_b, cur_merged, cur_target;

    assign cur_target = cfg_target[{ctl_idx, 3'b000} +: 8];

    otp_cond_eval #(.VW(VW)) i_cond (
        .mode_full (mode_full),
        .mode_cfg  (mode_cfg),
        .lock      (lock),
        .stack_v   (stack_v),
        .temp      (temp),
        .v_min     (v_min),
        .v_max     (v_max),
        .t_max     (t_max),
        .env_flt   (env_flt)
    );

    otp_image_store #(.N_BYTES(N_BYTES)) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (we),
        .wsel        (wsel),
        .waddr       (ctl_idx),
        .wdata       (wdata),
        .ctl_addr    (ctl_idx),
        .ctl_a       (cur_a),
        .ctl_b       (cur_b),
        .ctl_merged  (cur_merged),
        .host_addr   (rd_addr),
        .host_merged (rd_data)
    );

    otp_seq_ctrl #(
        .N_BYTES     (N_BYTES),
        .PROG_CYCLES (PROG_CYCLES),
        .SIG_SLOTS   (SIG_SLOTS)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_check  (req_check),
        .req_prog   (req_prog),
        .env_flt    (env_flt),
        .cur_a      (cur_a),
        .cur_b      (cur_b),
        .cur_merged (cur_merged),
        .cur_target (cur_target),
        .idx        (ctl_idx),
        .we         (we),
        .wsel       (wsel),
        .wdata      (wdata),
        .busy       (busy),
        .done       (done),
        .status     (status),
        .fail_addr  (fail_addr)
    );

endmodule

// File: tb/test_otp_prog_seq.sv
module test_otp_prog_seq;

    localparam int N  = 8;
    localparam int P  = 5;
    localparam int SG = 3;
    localparam int VW = 16;
    localparam int AW = $clog2(N);
    localparam int VMIN = 1000, VMAX = 2000, TMAX = 80;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_check = 1'b0, req_prog = 1'b0;
    logic mode_full = 1'b1, mode_cfg = 1'b1, lock = 1'b0;
    logic [VW-1:0] stack_v = 16'd1500, temp = 16'd25;
    logic [VW-1:0] v_min = 16'(VMIN), v_max = 16'(VMAX), t_max = 16'(TMAX);
    logic [N*8-1:0] cfg_target;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0] rd_data, status;
    logic busy, done;
    logic [15:0] fail_addr;

    int checks = 0, errors = 0;
    logic [7:0] exp_mem [N];
    int         use_cnt [N];
    int         sig_cnt = 0;

    always #4 clk = ~clk;

    otp_prog_seq #(.N_BYTES(N), .PROG_CYCLES(P), .SIG_SLOTS(SG), .VW(VW)) i_otp_prog_seq (
        .clk(clk), .rst_n(rst_n), .req_check(req_check), .req_prog(req_prog),
        .mode_full(mode_full), .mode_cfg(mode_cfg), .lock(lock),
        .stack_v(stack_v), .temp(temp), .v_min(v_min), .v_max(v_max), .t_max(t_max),
        .cfg_target(cfg_target), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .status(status), .fail_addr(fail_addr)
    );

    function automatic logic [7:0] dflt(input int i);
        return 8'((i * 29) ^ 165);
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic check_mem(input string req);
        for (int i = 0; i < N; i++) begin
            rd_addr = AW'(i);
            #1;
            chk(req, int'(rd_data), int'(exp_mem[i]));
        end
    endtask

    // is_prog: program request; both: raise both requests; poke: extra request mid-run
    task automatic run_op(input bit is_prog, input bit both, input bit poke, input string req);
        bit serve_prog;
        logic [5:0] f;
        int k, fa, cnt, guard, exp_busy, exp_stat;
        bit nd;
        serve_prog = is_prog && !both;
        f = '0;
        f[5] = !(mode_full && mode_cfg) || lock;
        f[4] = sig_cnt == SG;
        f[2] = temp > t_max;
        f[1] = stack_v < v_min;
        f[0] = stack_v > v_max;
        nd = 1'b0; fa = 0; k = 0;
        for (int i = 0; i < N; i++) begin
            if (cfg_target[i*8 +: 8] != exp_mem[i]) begin
                k++;
                if (use_cnt[i] == 2 && !nd) begin
                    nd = 1'b1;
                    fa = i;
                end
            end
        end
        f[3] = nd;
        exp_stat = (f == 6'd0) ? 8'h80 : int'(f);
        if (serve_prog && f == 6'd0) begin
            exp_busy = 2 * N + 1 + k * P;
        end else begin
            exp_busy = N + 1;
        end
        @(negedge clk);
        req_check = !is_prog || both;
        req_prog  = is_prog;
        @(negedge clk);
        req_check = 1'b0;
        req_prog  = 1'b0;
        cnt = 0; guard = 0;
        while (!done && guard < 10000) begin
            if (busy) cnt++;
            req_prog = poke && (cnt == 3);
            @(negedge clk);
            guard++;
        end
        req_prog = 1'b0;
        chk({req, " status"}, int'(status), exp_stat);
        chk({req, " fail_addr"}, int'(fail_addr), fa);
        chk({req, " busy length"}, cnt, exp_busy);
        if (serve_prog && f == 6'd0) begin
            for (int i = 0; i < N; i++) begin
                if (cfg_target[i*8 +: 8] != exp_mem[i]) begin
                    exp_mem[i] = cfg_target[i*8 +: 8];
                    use_cnt[i]++;
                end
            end
            sig_cnt++;
        end
        check_mem({req, " contents"});
    endtask

    task automatic set_target_default;
        for (int i = 0; i < N; i++) cfg_target[i*8 +: 8] = dflt(i);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            exp_mem[i] = dflt(i);
            use_cnt[i] = 0;
        end
        set_target_default();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", int'(busy), 0);
        chk("R11 done", int'(done), 0);
        chk("R11 status", int'(status), 0);
        chk("R11 fail_addr", int'(fail_addr), 0);
        check_mem("R11 defaults");

        // R1 R2 R3 sweep of modes, lock, voltage and temperature
        for (int m = 0; m < 8; m++) begin
            for (int v = 0; v < 4; v++) begin
                for (int t = 0; t < 2; t++) begin
                    mode_full = m[0];
                    mode_cfg  = m[1];
                    lock      = m[2];
                    case (v)
                        0: stack_v = 16'(VMIN - 1);
                        1: stack_v = 16'(VMIN);
                        2: stack_v = 16'(VMAX);
                        default: stack_v = 16'(VMAX + 1);
                    endcase
                    temp = (t == 0) ? 16'(TMAX) : 16'(TMAX + 1);
                    run_op(1'b0, 1'b0, 1'b0, "R1 R2 R3 R6 sweep");
                end
            end
        end
        mode_full = 1'b1; mode_cfg = 1'b1; lock = 1'b0;
        stack_v = 16'd1500; temp = 16'd25;

        // R10 both requests together: check wins, nothing written
        set_target_default();
        cfg_target[1*8 +: 8] = dflt(1) ^ 8'h0F;
        cfg_target[2*8 +: 8] = dflt(2) ^ 8'h0F;
        cfg_target[5*8 +: 8] = dflt(5) ^ 8'h0F;
        run_op(1'b1, 1'b1, 1'b0, "R10 both requests");

        // R9 program refused when locked
        lock = 1'b1;
        run_op(1'b1, 1'b0, 1'b0, "R9 locked program");
        lock = 1'b0;

        // R7 R8 R10 program three bytes with a request poked while busy
        run_op(1'b1, 1'b0, 1'b1, "R7 R8 R10 program k=3");
        repeat (4) begin
            @(negedge clk);
            chk("R10 no extra operation", int'(busy), 0);
        end

        // R8 same target again, nothing changes
        run_op(1'b1, 1'b0, 1'b0, "R8 program k=0");

        // R7 second image used for bytes 2 and 5
        cfg_target[2*8 +: 8] = cfg_target[2*8 +: 8] ^ 8'h30;
        cfg_target[5*8 +: 8] = cfg_target[5*8 +: 8] ^ 8'h30;
        run_op(1'b1, 1'b0, 1'b0, "R7 R8 second image");

        // R4 R5 slots exhausted, lowest failing address reported
        cfg_target[2*8 +: 8] = cfg_target[2*8 +: 8] ^ 8'h01;
        cfg_target[5*8 +: 8] = cfg_target[5*8 +: 8] ^ 8'h01;
        cfg_target[6*8 +: 8] = cfg_target[6*8 +: 8] ^ 8'h01;
        run_op(1'b0, 1'b0, 1'b0, "R4 R5 check exhausted");
        run_op(1'b1, 1'b0, 1'b0, "R4 R5 R9 program exhausted");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule